// File: doc/BRIEF.md
# Prioritised Interrupt Controller

The block gathers 32 level-sensitive requests from on-chip peripherals and presents them to a processor on two lines. One is a fast-interrupt line and the other is a normal-interrupt line. A routing register decides, bit by bit, which line each source drives. An enable register gates each source. Software reads the unmasked request levels, the enabled-and-pending set, and one code per line that names the pending source to service first.

Sources are grouped by the peripheral that owns them. The groups are communications channel (0–1), external pins (2–5), timers (6–7), serial port (8–11), LAN MAC (12–17), home-network MAC (18–23), bus error (24) and WAN MAC (25–31).

Each group has one priority register. It holds a 4-bit field per member source, and a larger value wins. The "first to service" code picks the source with the largest field. When fields are equal, the lowest source number wins. All access uses a simple 32-bit register bus: word address, write strobe, write data, and read data that is combinational on the address.

Top module: `prio_intc`

## Requirements
- R1: After reset, the routing, enable and all priority registers read 0, both lines are low, and both first-to-service codes read 0xFF.
- R2: A write to offset 0x00 (routing, bit n = 1 sends source n to the fast line) or 0x04 (enable, bit n = 1 enables source n) is read back unchanged at the same offset from the next cycle on.
- R3: Offset 0x08 reads the live request inputs, bit n for source n, whatever the enable and routing settings.
- R4: Offset 0x2C reads the request inputs ANDed with the enable register; zero means nothing to service.
- R5: `fiq_o` is the OR of the enabled pending sources whose routing bit is 1. `irq_o` is the OR of those whose routing bit is 0.
- R6: Priority registers decode as follows, with source (base+k) in bits [4k+3:4k] and unused upper bits reading 0: 0x0C sources 25–31, 0x10 sources 18–23, 0x14 sources 12–17, 0x18 sources 6–7, 0x1C sources 8–11, 0x20 sources 2–5, 0x24 sources 0–1, 0x28 source 24.
- R7: Offsets 0x30 (fast line) and 0x34 (normal line) return, in bits [7:0], the number of the enabled pending source routed to that line with the largest priority field. Ties go to the lowest source number, and bits [31:8] are 0.
- R8: When no enabled pending source is routed to a line, its code at 0x30 or 0x34 reads 0xFF, and that line is low.
- R9: Writes to 0x08, 0x2C, 0x30, 0x34 or any unmapped offset change no register, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 32 | Level request per source |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fiq_o | output | 1 | Fast interrupt request line |
| irq_o | output | 1 | Normal interrupt request line |

## Verification
On every cycle, the assertions check four things. Each line equals the OR of its routed, enabled requests. A line is high exactly when its code is not 0xFF. Any reported code names a source that is pending, enabled and routed to that line. Routing and enable writes take effect, and writes to read-only or unmapped offsets leave them alone. Only the bench scenarios can show which source wins the priority search: the comparison of fields across groups, the lowest-number tie-break, and the bit placement inside each priority register. These all depend on programmed values that the properties do not model.

// File: rtl/prio_intc_pkg.sv
`timescale 1ns/1ps
package prio_intc_pkg;
   localparam int NUM_GROUPS  = 8;
   // word index (byte offset / 4) of each register
   localparam int WRD_ROUTE   = 0;
   localparam int WRD_ENABLE  = 1;
   localparam int WRD_RAW     = 2;
   localparam int WRD_PRIO0   = 3;
   localparam int WRD_PRIO_N  = WRD_PRIO0 + NUM_GROUPS - 1;
   localparam int WRD_MASKED  = 11;
   localparam int WRD_HP_FAST = 12;
   localparam int WRD_HP_NORM = 13;

   // priority-register slot (0..7) that owns a source
   function automatic int grp_of(input int s);
      if (s >= 25)      return 0;
      else if (s == 24) return 7;
      else if (s >= 18) return 1;
      else if (s >= 12) return 2;
      else if (s >= 8)  return 4;
      else if (s >= 6)  return 3;
      else if (s >= 2)  return 5;
      else              return 6;
   endfunction

   // lowest source number held by a priority-register slot
   function automatic int grp_base(input int g);
      case (g)
         0:       return 25;
         1:       return 18;
         2:       return 12;
         3:       return 6;
         4:       return 8;
         5:       return 2;
         6:       return 0;
         default: return 24;
      endcase
   endfunction
endpackage

// File: rtl/prio_intc_regs.sv
`timescale 1ns/1ps
module prio_intc_regs
   import prio_intc_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int PW   = 4,
   parameter int AW   = 8,
   parameter int DW   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-3:0]    word,
   input  logic [DW-1:0]    wdata,
   output logic [NSRC-1:0]  route_q,
   output logic [NSRC-1:0]  en_q,
   output logic [NSRC*PW-1:0] prio_q
);
   localparam int WW = AW - 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
         en_q    <= '0;
      end else if (wr_en) begin
         if (word == WW'(WRD_ROUTE))  route_q <= wdata[NSRC-1:0];
         if (word == WW'(WRD_ENABLE)) en_q    <= wdata[NSRC-1:0];
      end
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_prio
      localparam int GRP = grp_of(s);
      localparam int FLD = (s - grp_base(GRP)) * PW;
      logic [PW-1:0] fld_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld_r <= '0;
         else if (wr_en && word == WW'(WRD_PRIO0 + GRP))
            fld_r <= wdata[FLD +: PW];
      end
      assign prio_q[s*PW +: PW] = fld_r;
   end
endmodule

// File: rtl/prio_intc_pick.sv
`timescale 1ns/1ps
module prio_intc_pick #(
   parameter int NSRC = 32,
   parameter int PW   = 4,
   parameter int IW   = 8,
   parameter logic [IW-1:0] NONE = '1
) (
   input  logic [NSRC-1:0]    pend,
   input  logic [NSRC*PW-1:0] prio,
   output logic [IW-1:0]      code
);
   logic          found_c;
   logic [PW-1:0] best_c;

   // strict "greater than" keeps the lowest index on equal fields
   always_comb begin
      found_c = 1'b0;
      best_c  = '0;
      code    = NONE;
      for (int i = 0; i < NSRC; i++) begin
         if (pend[i] && (!found_c || prio[i*PW +: PW] > best_c)) begin
            found_c = 1'b1;
            best_c  = prio[i*PW +: PW];
            code    = IW'(i);
         end
      end
   end
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int PW   = 4,
   parameter int AW   = 8,
   parameter int DW   = 32,
   parameter int IW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     irq_src,
   input  logic [7:0]      bus_addr,
   input  logic            bus_we,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic            fiq_o,
   output logic            irq_o
);
   localparam int WW = AW - 2;
   localparam logic [IW-1:0] NONE_CODE = '1;

   if (NSRC != 32) begin : g_chk_nsrc
      $error("prio_intc: source map is fixed at 32 sources");
   end
   if (PW * 7 > DW) begin : g_chk_pw
      $error("prio_intc: largest group does not fit the data word");
   end
   if (AW != 8 || DW != 32) begin : g_chk_bus
      $error("prio_intc: port widths assume an 8-bit address and 32-bit data");
   end
   if ((1 << IW) <= NSRC) begin : g_chk_iw
      $error("prio_intc: code width cannot hold the reserved none value");
   end

   logic [WW-1:0]      word;
   logic [NSRC-1:0]    route_q, en_q, masked;
   logic [NSRC*PW-1:0] prio_q;
   logic [IW-1:0]      hp_code [2];
   logic [IW-1:0]      hp_fast_code, hp_norm_code;
   logic [DW-1:0]      prio_rd;

   assign word = bus_addr[AW-1:2];

   prio_intc_regs #(.NSRC(NSRC), .PW(PW), .AW(AW), .DW(DW)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we),
      .word    (word),
      .wdata   (bus_wdata),
      .route_q (route_q),
      .en_q    (en_q),
      .prio_q  (prio_q)
   );

   assign masked = irq_src & en_q;

   // line 0: fast (route bit 1), line 1: normal (route bit 0)
   for (genvar o = 0; o < 2; o++) begin : g_line
      logic [NSRC-1:0] pend;
      assign pend = (o == 0) ? (masked & route_q) : (masked & ~route_q);
      prio_intc_pick #(.NSRC(NSRC), .PW(PW), .IW(IW), .NONE(NONE_CODE)) pick_i (
         .pend (pend),
         .prio (prio_q),
         .code (hp_code[o])
      );
   end

   assign hp_fast_code = hp_code[0];
   assign hp_norm_code = hp_code[1];
   assign fiq_o = |(masked & route_q);
   assign irq_o = |(masked & ~route_q);

   always_comb begin
      prio_rd = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (word == WW'(WRD_PRIO0 + grp_of(s)))
            prio_rd[(s - grp_base(grp_of(s)))*PW +: PW] = prio_q[s*PW +: PW];
      end
   end

   always_comb begin
      case (word)
         WW'(WRD_ROUTE):   bus_rdata = route_q;
         WW'(WRD_ENABLE):  bus_rdata = en_q;
         WW'(WRD_RAW):     bus_rdata = irq_src;
         WW'(WRD_MASKED):  bus_rdata = masked;
         WW'(WRD_HP_FAST): bus_rdata = DW'(hp_fast_code);
         WW'(WRD_HP_NORM): bus_rdata = DW'(hp_norm_code);
         default:
            bus_rdata = (word >= WW'(WRD_PRIO0) && word <= WW'(WRD_PRIO_N)) ? prio_rd : '0;
      endcase
   end
endmodule

// File: rtl/prio_intc_sva.sv
`timescale 1ns/1ps
module prio_intc_sva #(
   parameter int NSRC = 32,
   parameter int IW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] irq_src,
   input logic [7:0]      bus_addr,
   input logic            bus_we,
   input logic [31:0]     bus_wdata,
   input logic            fiq_o,
   input logic            irq_o,
   input logic [NSRC-1:0] route_q,
   input logic [NSRC-1:0] en_q,
   input logic [IW-1:0]   hp_fast_code,
   input logic [IW-1:0]   hp_norm_code
);
   logic [5:0] w;
   assign w = bus_addr[7:2];

   p_fast_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o == |(irq_src & en_q & route_q));

   p_norm_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == |(irq_src & en_q & ~route_q));

   p_fast_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o == (hp_fast_code != 8'hFF));

   p_norm_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (hp_norm_code != 8'hFF));

   p_fast_code_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_fast_code != 8'hFF) |->
         (irq_src[hp_fast_code[4:0]] && en_q[hp_fast_code[4:0]] && route_q[hp_fast_code[4:0]]));

   p_norm_code_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_norm_code != 8'hFF) |->
         (irq_src[hp_norm_code[4:0]] && en_q[hp_norm_code[4:0]] && !route_q[hp_norm_code[4:0]]));

   p_route_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && w == 6'd0) |=> (route_q == $past(bus_wdata)));

   p_enable_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && w == 6'd1) |=> (en_q == $past(bus_wdata)));

   p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (w == 6'd2 || w >= 6'd11)) |=> ($stable(route_q) && $stable(en_q)));
endmodule

bind prio_intc prio_intc_sva #(.NSRC(NSRC), .IW(IW)) sva_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_src      (irq_src),
   .bus_addr     (bus_addr),
   .bus_we       (bus_we),
   .bus_wdata    (bus_wdata),
   .fiq_o        (fiq_o),
   .irq_o        (irq_o),
   .route_q      (route_q),
   .en_q         (en_q),
   .hp_fast_code (hp_fast_code),
   .hp_norm_code (hp_norm_code)
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_src = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fiq_o, irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   prio_intc dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_src   (irq_src),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .fiq_o     (fiq_o),
      .irq_o     (irq_o)
   );

   // {src, enable, route, exp masked, exp fast code, exp normal code}
   // priorities in force: src3=2, src9=5, src24=15, src30=5, others 0
   localparam int NV = 9;
   localparam logic [143:0] VEC [NV] = '{
      {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 8'hFF, 8'hFF},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 8'hFF, 8'd24},
      {32'h0000_000F, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_000F, 8'hFF, 8'd3},
      {32'h4000_0200, 32'hFFFF_FFFF, 32'h0000_0000, 32'h4000_0200, 8'hFF, 8'd9},
      {32'h4000_0200, 32'hFFFF_FFFF, 32'h4000_0000, 32'h4000_0200, 8'd30, 8'd9},
      {32'h0000_0006, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0006, 8'hFF, 8'd1},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0100_0000, 32'hFFFF_FFFF, 8'd24, 8'd9},
      {32'hFFFF_FFFF, 32'hFEFF_FDFF, 32'h0000_0000, 32'hFEFF_FDFF, 8'hFF, 8'd30},
      {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 8'hFF, 8'hFF}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #5;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, d); chk("R1 route", d, 32'h0);
      rd(8'h04, d); chk("R1 enable", d, 32'h0);
      rd(8'h0C, d); chk("R1 prio", d, 32'h0);
      rd(8'h30, d); chk("R1 fast code", d, 32'hFF);
      rd(8'h34, d); chk("R1 normal code", d, 32'hFF);
      chk("R1 lines", {30'd0, fiq_o, irq_o}, 32'h0);

      // R2 readback
      wr(8'h00, 32'hA5A5_0F0F); rd(8'h00, d); chk("R2 route", d, 32'hA5A5_0F0F);
      wr(8'h04, 32'h1234_8765); rd(8'h04, d); chk("R2 enable", d, 32'h1234_8765);

      // R6 field layout and width per group
      wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R6 group 0x0C", d, 32'h0FFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk("R6 group 0x28", d, 32'h0000_000F);
      wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d); chk("R6 group 0x18", d, 32'h0000_00FF);
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R6 group 0x10", d, 32'h00FF_FFFF);
      rd(8'h14, d); chk("R6 untouched group 0x14", d, 32'h0);
      wr(8'h10, 32'h0); wr(8'h18, 32'h0);
      wr(8'h0C, 32'h0050_0000);   // source 30 = 5
      wr(8'h1C, 32'h0000_0050);   // source 9 = 5
      wr(8'h20, 32'h0000_0020);   // source 3 = 2
      wr(8'h28, 32'h0000_000F);   // source 24 = 15
      rd(8'h1C, d); chk("R6 group 0x1C", d, 32'h0000_0050);

      // vector table: R3 R4 R5 R7 R8
      for (int v = 0; v < NV; v++) begin
         wr(8'h04, VEC[v][111:80]);
         wr(8'h00, VEC[v][79:48]);
         @(negedge clk);
         irq_src = VEC[v][143:112];
         rd(8'h08, d); chk($sformatf("R3 raw v%0d", v), d, VEC[v][143:112]);
         rd(8'h2C, d); chk($sformatf("R4 masked v%0d", v), d, VEC[v][47:16]);
         rd(8'h30, d); chk($sformatf("R7 fast code v%0d", v), d, {24'd0, VEC[v][15:8]});
         rd(8'h34, d); chk($sformatf("R7 normal code v%0d", v), d, {24'd0, VEC[v][7:0]});
         chk($sformatf("R5 R8 fiq_o v%0d", v), {31'd0, fiq_o}, {31'd0, VEC[v][15:8] != 8'hFF});
         chk($sformatf("R5 R8 irq_o v%0d", v), {31'd0, irq_o}, {31'd0, VEC[v][7:0] != 8'hFF});
      end

      // R9 ignored writes
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h00, 32'h4000_0000);
      irq_src = 32'h4000_0200;
      wr(8'h08, 32'h0000_0000);
      wr(8'h2C, 32'h0000_0000);
      wr(8'h30, 32'h0000_0000);
      wr(8'h34, 32'hFFFF_FFFF);
      wr(8'h38, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      rd(8'h00, d); chk("R9 route kept", d, 32'h4000_0000);
      rd(8'h04, d); chk("R9 enable kept", d, 32'hFFFF_FFFF);
      rd(8'h0C, d); chk("R9 prio kept", d, 32'h0050_0000);
      rd(8'h08, d); chk("R9 raw still live", d, 32'h4000_0200);
      rd(8'h30, d); chk("R9 fast code kept", d, 32'd30);
      rd(8'h38, d); chk("R9 unmapped reads 0", d, 32'h0);

      // R7 tie between groups resolved by lowest number; R8 none after disable
      wr(8'h00, 32'h0);
      rd(8'h34, d); chk("R7 tie lowest", d, 32'd9);
      wr(8'h04, 32'h0);
      rd(8'h34, d); chk("R8 none when disabled", d, 32'hFF);
      chk("R8 line low", {31'd0, irq_o}, 32'h0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule